// File: doc/BRIEF.md
# Bitfield Clear and Insert Unit

This block is a 32-bit execution datapath for two field operations on a destination word. The clear operation zeroes a contiguous run of bits. The insert operation fills that run with the low-order bits of a source word. In both cases the field is given by a start position and a width, and every bit outside the field keeps its destination value.

Each request is qualified by a 4-bit condition code, which is evaluated against the incoming NZCV flags. An out-of-range field, or a register index that names the stack pointer or the program counter, makes the request illegal. When a request is illegal or its condition fails, the write is suppressed and the destination value passes through unchanged. The flags are carried through the block without modification. The result is registered and comes out one cycle after the request.

Top module: `bfu_unit`

## Requirements
- R1: With `in_op`=0 (clear), bits [lsb+width-1:lsb] of the result are zero and all other bits equal `in_dst`.
- R2: With `in_op`=1 (insert), bits [lsb+width-1:lsb] of the result equal `in_src[width-1:0]` and all other bits equal `in_dst`.
- R3: A field that reaches the top bit (lsb+width = 32) is legal; lsb 0 with width 32 replaces or clears the whole word.
- R4: A width of 0, or lsb+width greater than 32, raises `out_illegal`, holds `out_wen` low and returns `in_dst` unchanged.
- R5: A destination index of 13 or 15 is illegal for both operations; a source index of 13 or 15 is illegal only for insert, and clear ignores the source index.
- R6: The condition is evaluated with N=`in_flags[3]`, Z=`in_flags[2]`, C=`in_flags[1]`, V=`in_flags[0]`. The codes 0 to 13 mean in turn: Z, !Z, C, !C, N, !N, V, !V, C&!Z, !C|Z, N==V, N!=V, !Z&(N==V), Z|(N!=V). Codes 14 and 15 always pass.
- R7: A failed condition holds `out_wen` low and returns `in_dst`, and it does not change `out_illegal`.
- R8: `out_flags` equals the `in_flags` of the request that produced the output, so the flags are never altered.
- R9: `out_valid` is high exactly in the cycle after `in_valid` is high. `out_wen` is high only together with `out_valid`.
- R10: A synchronous active-high reset drives `out_valid`, `out_wen`, `out_illegal`, `out_result` and `out_flags` to zero.
- R11: With start 8 and width 12, exactly bits 8 to 19 are affected; on insert they come from source bits 0 to 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 1 | 0 = clear field, 1 = insert field |
| in_dst | input | 32 | Current destination value |
| in_src | input | 32 | Source value for insert |
| in_lsb | input | 5 | Field start position |
| in_width | input | 6 | Field width |
| in_cond | input | 4 | Condition code |
| in_flags | input | 4 | NZCV flags, N in bit 3 |
| in_rd_idx | input | 4 | Destination register index |
| in_rn_idx | input | 4 | Source register index |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_result | output | 32 | Value to write, or the destination unchanged |
| out_wen | output | 1 | Register write enable |
| out_illegal | output | 1 | Illegal field or register index |
| out_flags | output | 4 | Flags passed through unchanged |

## Verification
The field logic is first driven with directed fields. The fixed 8/12 case shows that the field boundaries sit where they should. Whole-word and top-bit fields expose an off-by-one in the mask at its limits, and zero-width and overflowing fields show whether range checking is done at all. Every condition code is swept against random flags, which separates each code's predicate from its neighbour and from its inverse. Random requests then mix both operations, all start positions, widths slightly past the legal limit and occasional forbidden indices, so that errors in the mask, the merge and the gating show up in combination.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

    typedef enum logic {
        BFU_CLEAR  = 1'b0,
        BFU_INSERT = 1'b1
    } bfu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_XX = 4'd15
    } bfu_cond_e;

    function automatic logic cond_pass(bfu_cond_e code, nzcv_t f);
        logic r;
        case (code)
            CC_EQ:   r = f.z;
            CC_NE:   r = !f.z;
            CC_CS:   r = f.c;
            CC_CC:   r = !f.c;
            CC_MI:   r = f.n;
            CC_PL:   r = !f.n;
            CC_VS:   r = f.v;
            CC_VC:   r = !f.v;
            CC_HI:   r = f.c && !f.z;
            CC_LS:   r = !f.c || f.z;
            CC_GE:   r = (f.n == f.v);
            CC_LT:   r = (f.n != f.v);
            CC_GT:   r = !f.z && (f.n == f.v);
            CC_LE:   r = f.z || (f.n != f.v);
            default: r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bfu_mask.sv
module bfu_mask #(
    parameter int DATA_W = 32,
    parameter int POS_W  = $clog2(DATA_W),
    parameter int WID_W  = POS_W + 1
) (
    input  logic [POS_W-1:0]  lsb,
    input  logic [WID_W-1:0]  width,
    output logic [DATA_W-1:0] mask,
    output logic              range_ok
);
    localparam int SPAN_W = WID_W + 1;

    logic [DATA_W:0]   ones;
    logic [SPAN_W-1:0] span;

    always_comb begin
        ones     = ({{DATA_W{1'b0}}, 1'b1} << width) - 1'b1;
        mask     = ones[DATA_W-1:0] << lsb;
        span     = SPAN_W'(lsb) + SPAN_W'(width);
        range_ok = (width != '0) && (span <= SPAN_W'(DATA_W));
    end
endmodule

// File: rtl/bfu_merge.sv
module bfu_merge #(
    parameter int DATA_W = 32,
    parameter int POS_W  = $clog2(DATA_W)
) (
    input  bfu_pkg::bfu_op_e  op,
    input  logic [DATA_W-1:0] dst,
    input  logic [DATA_W-1:0] src,
    input  logic [POS_W-1:0]  lsb,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] merged
);
    logic [DATA_W-1:0] src_aligned;
    logic              fill_en;

    assign src_aligned = src << lsb;
    assign fill_en     = (op == bfu_pkg::BFU_INSERT);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign merged[b] = mask[b] ? (fill_en & src_aligned[b]) : dst[b];
    end
endmodule

// File: rtl/bfu_unit.sv
module bfu_unit #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    parameter int SP_IDX = 13,
    parameter int PC_IDX = 15,
    localparam int POS_W = $clog2(DATA_W),
    localparam int WID_W = POS_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_op,
    input  logic [DATA_W-1:0] in_dst,
    input  logic [DATA_W-1:0] in_src,
    input  logic [POS_W-1:0]  in_lsb,
    input  logic [WID_W-1:0]  in_width,
    input  logic [3:0]        in_cond,
    input  logic [3:0]        in_flags,
    input  logic [IDX_W-1:0]  in_rd_idx,
    input  logic [IDX_W-1:0]  in_rn_idx,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_wen,
    output logic              out_illegal,
    output logic [3:0]        out_flags
);
    import bfu_pkg::*;

    bfu_op_e           op;
    logic [DATA_W-1:0] mask;
    logic              range_ok;
    logic [DATA_W-1:0] merged;
    logic              rd_bad;
    logic              rn_bad;
    logic              illegal;
    logic              pass;
    logic              commit;

    assign op = bfu_op_e'(in_op);

    bfu_mask #(.DATA_W(DATA_W), .POS_W(POS_W), .WID_W(WID_W)) u_mask (
        .lsb      (in_lsb),
        .width    (in_width),
        .mask     (mask),
        .range_ok (range_ok)
    );

    bfu_merge #(.DATA_W(DATA_W), .POS_W(POS_W)) u_merge (
        .op     (op),
        .dst    (in_dst),
        .src    (in_src),
        .lsb    (in_lsb),
        .mask   (mask),
        .merged (merged)
    );

    always_comb begin
        rd_bad  = (in_rd_idx == IDX_W'(SP_IDX)) || (in_rd_idx == IDX_W'(PC_IDX));
        rn_bad  = (op == BFU_INSERT) &&
                  ((in_rn_idx == IDX_W'(SP_IDX)) || (in_rn_idx == IDX_W'(PC_IDX)));
        illegal = !range_ok || rd_bad || rn_bad;
        pass    = cond_pass(bfu_cond_e'(in_cond), nzcv_t'(in_flags));
        commit  = !illegal && pass;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_wen     <= 1'b0;
            out_illegal <= 1'b0;
            out_result  <= '0;
            out_flags   <= '0;
        end else begin
            out_valid   <= in_valid;
            out_wen     <= in_valid && commit;
            out_illegal <= in_valid && illegal;
            if (in_valid) begin
                out_result <= commit ? merged : in_dst;
                out_flags  <= in_flags;
            end
        end
    end
endmodule

// File: rtl/bfu_unit_chk.sv
module bfu_unit_chk #(
    parameter int DATA_W = 32,
    parameter int WID_W  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_dst,
    input logic [WID_W-1:0]  in_width,
    input logic [3:0]        in_flags,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic              out_wen,
    input logic              out_illegal,
    input logic [3:0]        out_flags
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R9
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R9
    AST_WEN_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst) out_wen |-> out_valid); // R9
    AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (rst) in_valid |=> (out_flags == $past(in_flags))); // R8
    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst) out_illegal |-> !out_wen); // R4
    AST_ZERO_WIDTH_BAD: assert property (@(posedge clk) disable iff (rst) (in_valid && in_width == '0) |=> out_illegal); // R4
    AST_NOWRITE_PASSTHRU: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_wen) |-> (out_result == $past(in_dst))); // R7
endmodule

bind bfu_unit bfu_unit_chk #(.DATA_W(DATA_W), .WID_W(WID_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_dst      (in_dst),
    .in_width    (in_width),
    .in_flags    (in_flags),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_wen     (out_wen),
    .out_illegal (out_illegal),
    .out_flags   (out_flags)
);

// File: tb/tb_bfu_unit.sv
`timescale 1ns/1ps
module tb_bfu_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_op;
    logic [31:0] in_dst;
    logic [31:0] in_src;
    logic [4:0]  in_lsb;
    logic [5:0]  in_width;
    logic [3:0]  in_cond;
    logic [3:0]  in_flags;
    logic [3:0]  in_rd_idx;
    logic [3:0]  in_rn_idx;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_wen;
    logic        out_illegal;
    logic [3:0]  out_flags;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bfu_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_src(in_src), .in_lsb(in_lsb), .in_width(in_width),
        .in_cond(in_cond), .in_flags(in_flags), .in_rd_idx(in_rd_idx),
        .in_rn_idx(in_rn_idx), .out_valid(out_valid), .out_result(out_result),
        .out_wen(out_wen), .out_illegal(out_illegal), .out_flags(out_flags)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Condition predicate as a pair table: even code = base, odd = inverse.
    function automatic logic exp_cond(logic [3:0] code, logic [3:0] f);
        logic n, z, c, v, base;
        n = f[3]; z = f[2]; c = f[1]; v = f[0];
        case (code[3:1])
            3'd0: base = z;
            3'd1: base = c;
            3'd2: base = n;
            3'd3: base = v;
            3'd4: base = c & ~z;
            3'd5: base = ~(n ^ v);
            3'd6: base = ~z & ~(n ^ v);
            default: return 1'b1;
        endcase
        return code[0] ? ~base : base;
    endfunction

    function automatic logic exp_illegal(logic op, logic [4:0] lsb, logic [5:0] w,
                                         logic [3:0] rd, logic [3:0] rn);
        int top;
        top = int'(lsb) + int'(w);
        if (w == 0 || top > 32) return 1'b1;
        if (rd == 4'd13 || rd == 4'd15) return 1'b1;
        if (op && (rn == 4'd13 || rn == 4'd15)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] exp_field(logic op, logic [31:0] d, logic [31:0] s,
                                              logic [4:0] lsb, logic [5:0] w);
        logic [31:0] r;
        r = d;
        for (int i = 0; i < 32; i++) begin
            if (i >= int'(lsb) && i < int'(lsb) + int'(w))
                r[i] = op ? s[i - int'(lsb)] : 1'b0;
        end
        return r;
    endfunction

    task automatic apply(string tag, logic op, logic [31:0] d, logic [31:0] s,
                         logic [4:0] lsb, logic [5:0] w, logic [3:0] cc,
                         logic [3:0] fl, logic [3:0] rd, logic [3:0] rn);
        logic bad, ok, wen;
        logic [31:0] res;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_dst = d; in_src = s; in_lsb = lsb;
        in_width = w; in_cond = cc; in_flags = fl; in_rd_idx = rd; in_rn_idx = rn;
        bad = exp_illegal(op, lsb, w, rd, rn);
        ok  = exp_cond(cc, fl);
        wen = !bad && ok;
        res = wen ? exp_field(op, d, s, lsb, w) : d;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R9 valid"}, 32'(out_valid), 32'd1);
        check({tag, " wen"}, 32'(out_wen), 32'(wen));
        check({tag, " illegal"}, 32'(out_illegal), 32'(bad));
        check({tag, " result"}, out_result, res);
        check({tag, " R8 flags"}, 32'(out_flags), 32'(fl));
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        logic [5:0] w;
        logic [3:0] rd, rn;
        seed = $urandom(32'd2024);
        rst = 1'b1; in_valid = 1'b0; in_op = 1'b0; in_dst = '0; in_src = '0;
        in_lsb = '0; in_width = '0; in_cond = '0; in_flags = '0;
        in_rd_idx = '0; in_rn_idx = '0;
        repeat (2) @(negedge clk);
        in_valid = 1'b1; in_dst = 32'hFFFF_FFFF; in_width = 6'd4; in_cond = 4'd14;
        in_flags = 4'hF;
        @(negedge clk);
        // R10: reset holds outputs at zero even with a request present
        check("R10 valid", 32'(out_valid), 32'd0);
        check("R10 wen", 32'(out_wen), 32'd0);
        check("R10 illegal", 32'(out_illegal), 32'd0);
        check("R10 result", out_result, 32'd0);
        check("R10 flags", 32'(out_flags), 32'd0);
        in_valid = 1'b0;
        rst = 1'b0;

        // R11 / R1 / R2: the 8..19 field
        apply("R11 R1 clear", 1'b0, 32'hFFFF_FFFF, 32'h0, 5'd8, 6'd12, 4'd14, 4'h0, 4'd1, 4'd2);
        check("R11 clear value", out_result, 32'hFFF0_00FF);
        apply("R11 R2 insert", 1'b1, 32'h0, 32'h1234_5ABC, 5'd8, 6'd12, 4'd14, 4'h0, 4'd1, 4'd2);
        check("R11 insert value", out_result, 32'h000A_BC00);
        apply("R2 insert zeros", 1'b1, 32'hFFFF_FFFF, 32'h0, 5'd8, 6'd12, 4'd14, 4'h5, 4'd9, 4'd2);
        check("R2 insert zero value", out_result, 32'hFFF0_00FF);

        // R3: fields at the top boundary
        apply("R3 full insert", 1'b1, 32'hDEAD_BEEF, 32'h1357_9BDF, 5'd0, 6'd32, 4'd14, 4'h0, 4'd0, 4'd1);
        check("R3 full value", out_result, 32'h1357_9BDF);
        apply("R3 full clear", 1'b0, 32'hDEAD_BEEF, 32'h0, 5'd0, 6'd32, 4'd15, 4'h0, 4'd0, 4'd1);
        apply("R3 top bit", 1'b1, 32'h0, 32'h1, 5'd31, 6'd1, 4'd14, 4'h0, 4'd3, 4'd4);
        check("R3 top bit value", out_result, 32'h8000_0000);
        apply("R3 lsb20 w12", 1'b0, 32'hFFFF_FFFF, 32'h0, 5'd20, 6'd12, 4'd14, 4'h0, 4'd3, 4'd4);

        // R4: illegal ranges
        apply("R4 zero width", 1'b1, 32'hA5A5_A5A5, 32'hFFFF_FFFF, 5'd4, 6'd0, 4'd14, 4'h0, 4'd1, 4'd2);
        apply("R4 overflow", 1'b0, 32'hA5A5_A5A5, 32'h0, 5'd8, 6'd25, 4'd14, 4'h0, 4'd1, 4'd2);
        apply("R4 width 33", 1'b1, 32'h1111_2222, 32'hFFFF_FFFF, 5'd0, 6'd33, 4'd14, 4'h0, 4'd1, 4'd2);

        // R5: forbidden indices
        apply("R5 rd13", 1'b0, 32'hFFFF_FFFF, 32'h0, 5'd0, 6'd8, 4'd14, 4'h0, 4'd13, 4'd2);
        apply("R5 rd15", 1'b1, 32'hFFFF_FFFF, 32'h0, 5'd0, 6'd8, 4'd14, 4'h0, 4'd15, 4'd2);
        apply("R5 rn13 insert", 1'b1, 32'hFFFF_FFFF, 32'h0, 5'd0, 6'd8, 4'd14, 4'h0, 4'd2, 4'd13);
        apply("R5 rn15 clear ok", 1'b0, 32'hFFFF_FFFF, 32'h0, 5'd0, 6'd8, 4'd14, 4'h0, 4'd2, 4'd15);

        // R6 / R7: every code against several flag patterns
        for (int cc = 0; cc < 16; cc++) begin
            for (int k = 0; k < 6; k++) begin
                apply("R6 R7 cond", 1'b1, $urandom, $urandom, 5'd4, 6'd8, 4'(cc),
                      4'($urandom), 4'd1, 4'd2);
            end
        end
        // R7: failed condition with illegal field keeps illegal high
        apply("R7 fail+illegal", 1'b0, 32'h1234_5678, 32'h0, 5'd4, 6'd0, 4'd0, 4'h0, 4'd1, 4'd2);

        // R9: idle cycle produces no valid and no write
        @(negedge clk);
        check("R9 idle valid", 32'(out_valid), 32'd0);
        check("R9 idle wen", 32'(out_wen), 32'd0);

        // Random mix covering R1 R2 R4 R5 R6
        for (int i = 0; i < 400; i++) begin
            w  = 6'($urandom_range(0, 34));
            rd = ($urandom_range(0, 19) == 0) ? 4'd13 : 4'($urandom_range(0, 12));
            rn = ($urandom_range(0, 19) == 0) ? 4'd15 : 4'($urandom_range(0, 12));
            apply("R1 R2 random", 1'($urandom), $urandom, $urandom, 5'($urandom),
                  w, ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'd14,
                  4'($urandom), rd, rn);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule